// File: doc/BRIEF.md
# Power-fail write-protect gate

This block sits between a host memory bus and an asynchronous byte-wide static RAM. It shields the RAM from accesses while the supply is out of tolerance. A raw power-fail flag from an external comparator passes through a two-flop synchronizer. The host chip-enable, write-enable and output-enable strobes (all active low) are passed to the RAM only while power is good. The block also drives the enable for the data-bus drivers and a write-protect status flag.

When power fails, an access that is already running may finish. A grace timer cuts it off if it runs too long. Once the supply returns, protection stays for a recovery period. After that, the gate reopens only while the host chip enable is high, so the RAM never sees a truncated cycle. Both times are set in microseconds and converted to clock cycles from the clock frequency. The host strobes are taken to be synchronous to the block clock. Reset is synchronous and active high.

Top module: `pfwp_gate`

## Requirements
- R1: Reset starts the block protected, with `wp_active` high and all RAM strobes high. Accesses are accepted only after the full recovery period (RECOVER_CYC cycles) has followed reset.
- R2: While unprotected, each RAM strobe follows its host strobe. The strobes are active low (0 = asserted). `dq_drive_en` is 1 only for a read: CE=0, WE=1, OE=0. Standby (CE=1), output-disabled (CE=0, WE=1, OE=1) and write (CE=0, WE=0) all give 0.
- R3: If CE falls while WE is already low, `dq_drive_en` stays 0 until CE rises again. This holds even if WE rises and OE falls in the meantime. A write in which WE falls after CE does not hold the bus off once WE has returned high.
- R4: Suppose power-fail asserts while no access is in progress (CE high, or CE low with WE and OE both high). Then, from the third clock edge after the flag, all RAM strobes are high. This includes forcing CE high while the host still holds it low.
- R5: While protected, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1 and `dq_drive_en` is 0, whatever the host strobes do.
- R6: Suppose power-fail is detected during an access (CE low with WE or OE low). The strobes keep passing until the host raises CE. Protection then takes effect at the next clock edge.
- R7: If such an access has not ended GRACE_CYC cycles after detection, protection is forced while CE is still low.
- R8: After the synchronized power-fail flag falls, protection stays for RECOVER_CYC cycles.
- R9: A power-fail assertion during the recovery period returns the block to protection and restarts the recovery period from the new deassertion.
- R10: When the recovery period ends while the host holds CE low, protection continues until CE is high.
- R11: `wp_active` is 1 exactly when the gated strobes are blocked, and 0 while they pass, including during a grace drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_async | input | 1 | Raw power-fail flag, high = supply invalid |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to the RAM |
| mem_we_n | output | 1 | Gated write enable to the RAM |
| mem_oe_n | output | 1 | Gated output enable to the RAM |
| dq_drive_en | output | 1 | Enables the data-bus drivers toward the host during reads |
| wp_active | output | 1 | High while accesses are blocked |

## Verification
The hardest case to reach from the ports is a recovery period that ends while the host holds chip enable low. Only then does the gate have to wait for an idle bus rather than reopen. The stimulus reaches it by starting protection with CE low and idle, then keeping CE low through the whole recovery period. It also re-pulses power-fail in the middle of a recovery period to show the restart. Short parameter values make both timer expiries reachable in a few dozen cycles.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;

    typedef enum logic [1:0] {
        ST_OPEN    = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_LOCKED  = 2'd2,
        ST_SETTLE  = 2'd3
    } gate_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    function automatic int us_to_cycles(input longint clk_khz, input longint us);
        longint c;
        c = (clk_khz * us) / 1000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic logic access_live(input strobe_t s);
        return !s.ce_n && (!s.we_n || !s.oe_n);
    endfunction

endpackage

// File: rtl/pfwp_sync2.sv
module pfwp_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pfwp_timer.sv
module pfwp_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (!done) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl
    import pfwp_pkg::*;
#(
    parameter int GRACE_CYC   = 16,
    parameter int RECOVER_CYC = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pf,
    input  strobe_t host,
    output logic    pass
);
    gate_state_e state, state_nx;
    logic grace_done, settle_done;

    pfwp_timer #(.LIMIT(GRACE_CYC)) u_grace (
        .clk(clk), .rst(rst), .run(state == ST_DRAIN), .done(grace_done)
    );

    pfwp_timer #(.LIMIT(RECOVER_CYC)) u_settle (
        .clk(clk), .rst(rst), .run(state == ST_SETTLE), .done(settle_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OPEN:   if (pf) state_nx = access_live(host) ? ST_DRAIN : ST_LOCKED;
            ST_DRAIN:  if (host.ce_n || grace_done) state_nx = ST_LOCKED;
            ST_LOCKED: if (!pf) state_nx = ST_SETTLE;
            ST_SETTLE: begin
                if (pf) state_nx = ST_LOCKED;
                else if (settle_done && host.ce_n) state_nx = ST_OPEN;
            end
            default:   state_nx = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_SETTLE;
        else     state <= state_nx;
    end

    assign pass = (state == ST_OPEN) || (state == ST_DRAIN);
endmodule

// File: rtl/pfwp_gate.sv
module pfwp_gate
    import pfwp_pkg::*;
#(
    parameter int CLK_KHZ    = 100000,
    parameter int GRACE_US   = 100,
    parameter int RECOVER_US = 80000
) (
    input  logic clk,
    input  logic rst,
    input  logic pf_async,
    input  logic host_ce_n,
    input  logic host_we_n,
    input  logic host_oe_n,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic mem_oe_n,
    output logic dq_drive_en,
    output logic wp_active
);
    localparam int GRACE_CYC   = us_to_cycles(CLK_KHZ, GRACE_US);
    localparam int RECOVER_CYC = us_to_cycles(CLK_KHZ, RECOVER_US);

    strobe_t host, gated;
    logic    pf_s, pass;
    logic    ce_prev_n, late_ce_hold;

    assign host = '{ce_n: host_ce_n, we_n: host_we_n, oe_n: host_oe_n};

    pfwp_sync2 u_sync (.clk(clk), .rst(rst), .d(pf_async), .q(pf_s));

    pfwp_ctrl #(.GRACE_CYC(GRACE_CYC), .RECOVER_CYC(RECOVER_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .pf(pf_s), .host(host), .pass(pass)
    );

    // A cycle whose CE falls while WE is already low keeps the bus released
    // until CE returns high.
    always_ff @(posedge clk) begin
        if (rst) begin
            ce_prev_n    <= 1'b1;
            late_ce_hold <= 1'b0;
        end else begin
            ce_prev_n <= host_ce_n;
            if (host_ce_n)
                late_ce_hold <= 1'b0;
            else if (ce_prev_n && !host_we_n)
                late_ce_hold <= 1'b1;
        end
    end

    assign gated = pass ? host : STROBE_IDLE;

    assign mem_ce_n    = gated.ce_n;
    assign mem_we_n    = gated.we_n;
    assign mem_oe_n    = gated.oe_n;
    assign dq_drive_en = !gated.ce_n && gated.we_n && !gated.oe_n && !late_ce_hold
                         && !(ce_prev_n && !host_ce_n && !host_we_n);
    assign wp_active   = !pass;
endmodule

// File: rtl/pfwp_gate_chk.sv
module pfwp_gate_chk #(
    parameter int GRACE_CYC   = 16,
    parameter int RECOVER_CYC = 64
) (
    input logic clk,
    input logic rst,
    input logic pf_async,
    input logic host_ce_n,
    input logic mem_ce_n,
    input logic mem_we_n,
    input logic mem_oe_n,
    input logic dq_drive_en,
    input logic wp_active
);
    localparam int CW = $clog2(RECOVER_CYC + GRACE_CYC + 8) + 1;

    logic [CW-1:0] quiet_cnt, pend_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_cnt <= '0;
            pend_cnt  <= '0;
        end else begin
            if (pf_async) quiet_cnt <= '0;
            else if (quiet_cnt != '1) quiet_cnt <= quiet_cnt + 1'b1;
            if (pf_async && !wp_active) pend_cnt <= pend_cnt + 1'b1;
            else pend_cnt <= '0;
        end
    end

    // R5 / R11: blocked means every strobe inactive and the bus released
    a_r5_blocked_idle: assert property (@(posedge clk) disable iff (rst)
        wp_active |-> (mem_ce_n && mem_we_n && mem_oe_n && !dq_drive_en));

    // R2: the bus is driven only during a gated read
    a_r2_drive_only_read: assert property (@(posedge clk) disable iff (rst)
        dq_drive_en |-> (!mem_ce_n && mem_we_n && !mem_oe_n));

    // R7: an access is never left open long after power fails
    a_r7_grace_bound: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= CW'(GRACE_CYC + 4));

    // R8 / R1: protection lifts only after a full quiet recovery window
    a_r8_recovery_len: assert property (@(posedge clk) disable iff (rst)
        $fell(wp_active) |-> (quiet_cnt >= CW'(RECOVER_CYC)));

    // R10: the gate reopens only while the host chip enable is high
    a_r10_open_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(wp_active) |-> $past(host_ce_n));
endmodule

bind pfwp_gate pfwp_gate_chk #(.GRACE_CYC(GRACE_CYC), .RECOVER_CYC(RECOVER_CYC)) u_chk (
    .clk(clk), .rst(rst), .pf_async(pf_async), .host_ce_n(host_ce_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .dq_drive_en(dq_drive_en), .wp_active(wp_active)
);

// File: tb/pfwp_gate_tb.sv
module pfwp_gate_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pf_async = 1'b0;
    logic host_ce_n = 1'b1, host_we_n = 1'b1, host_oe_n = 1'b1;
    logic mem_ce_n, mem_we_n, mem_oe_n, dq_drive_en, wp_active;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pfwp_gate #(.CLK_KHZ(1000), .GRACE_US(20), .RECOVER_US(50)) u_dut (
        .clk(clk), .rst(rst), .pf_async(pf_async),
        .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .dq_drive_en(dq_drive_en), .wp_active(wp_active)
    );

    // {ce,we,oe in, ce,we,oe out, dq_en}
    localparam logic [6:0] VEC [6] = '{
        7'b111_111_0, 7'b011_011_0, 7'b010_010_1,
        7'b001_001_0, 7'b000_000_0, 7'b110_110_0
    };

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host(input logic c, input logic w, input logic o);
        host_ce_n = c; host_we_n = w; host_oe_n = o;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int outs();
        return {28'd0, mem_ce_n, mem_we_n, mem_oe_n, dq_drive_en};
    endfunction

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 50000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        tick(3);
        #1 chk("R1 reset wp", wp_active, 1);
        chk("R1 reset strobes", outs(), 4'b1110);
        rst = 1'b0;
        tick(45); #1 chk("R1 still recovering", wp_active, 1);
        tick(10); #1 chk("R1 open after recovery", wp_active, 0);

        for (int k = 0; k < 6; k++) begin
            tick(1); host(1, 1, 1);
            tick(1); host(VEC[k][6], VEC[k][5], VEC[k][4]);
            #1 chk("R2 truth table", outs(), int'(VEC[k][3:0]));
            chk("R11 open flag", wp_active, 0);
        end

        // R3: CE falls with WE already low
        tick(1); host(1, 0, 1);
        tick(1); host(0, 0, 1);
        tick(1); host(0, 1, 0);
        #1 chk("R3 late CE keeps bus off", dq_drive_en, 0);
        tick(1); #1 chk("R3 still off", dq_drive_en, 0);
        tick(1); host(1, 1, 1);
        // WE-controlled write then read in same CE period
        tick(1); host(0, 1, 1);
        tick(1); host(0, 0, 1);
        tick(1); host(0, 1, 0);
        #1 chk("R3 WE-controlled write releases", dq_drive_en, 1);

        // R4: CE low idle, power fails
        tick(1); host(0, 1, 1); pf_async = 1'b1;
        tick(2); #1 chk("R4 not before sync", mem_ce_n, 0);
        tick(2); #1 chk("R4 CE forced high", mem_ce_n, 1);
        chk("R11 protected flag", wp_active, 1);
        host(0, 0, 0); #1 chk("R5 write ignored", outs(), 4'b1110);
        host(0, 1, 0); #1 chk("R5 read ignored", outs(), 4'b1110);
        host(0, 1, 1);
        tick(1); pf_async = 1'b0;
        tick(70); #1 chk("R10 wait for CE high", wp_active, 1);
        host(1, 1, 1);
        tick(2); #1 chk("R10 open after CE high", wp_active, 0);

        // R9: restart during recovery
        pf_async = 1'b1; tick(5); pf_async = 1'b0;
        tick(30); pf_async = 1'b1; tick(5); pf_async = 1'b0;
        tick(40); #1 chk("R9 recovery restarted", wp_active, 1);
        tick(25); #1 chk("R9 open after full window", wp_active, 0);

        // R6: in-flight read finishes
        host(0, 1, 0); tick(2); pf_async = 1'b1;
        tick(10); #1 chk("R6 read continues", outs(), 4'b0101);
        chk("R11 drain not blocked", wp_active, 0);
        host(1, 1, 1);
        tick(2); #1 chk("R6 protected after CE rise", wp_active, 1);
        pf_async = 1'b0;
        tick(60); #1 chk("R8 reopen", wp_active, 0);

        // R7: grace timeout cuts a hung access
        host(0, 1, 0); tick(2); pf_async = 1'b1;
        tick(15); #1 chk("R7 before timeout", mem_ce_n, 0);
        tick(15); #1 chk("R7 forced at timeout", mem_ce_n, 1);
        chk("R7 flag", wp_active, 1);
        host(1, 1, 1); pf_async = 1'b0;
        tick(45); #1 chk("R8 held during recovery", wp_active, 1);
        tick(15); #1 chk("R8 released after recovery", wp_active, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule